// File: doc/BRIEF.md
# Ethernet MAC Error Statistics Counter Bank

This block keeps fourteen narrow event counters for a gigabit Ethernet MAC. Seven of them count receive faults: frame check failures, alignment errors, length mismatches, code errors, overruns, fragments and dropped frames. The other seven count transmit events: single collisions, deferrals, multiple collisions, late collisions, the total of all collisions, underruns and oversize frames. The MAC datapath drives one single-cycle strobe for each condition. Every counter that receives a strobe advances by one on that clock edge.

The counters are narrow, so they wrap often. Host software extends them to full width. When a counter rolls over from all ones to zero, its bit in one of two carry status registers is set. Each carry register has a mask register beside it. Any carry bit whose mask bit is zero drives the interrupt line. Software reads the carry registers and adds one full counter revolution to its own copy for each set bit. It then writes the value it read back to the carry register, and every 1 written clears the matching bit. Software can also write a counter directly, and writing zero clears it.

A flat register port gives access to the block. The port has a write strobe, an address and write data, and the read data follows the address combinationally.

Top module: `mac_err_stats`

## Requirements
- R1: After reset every counter reads 0, both carry registers read 0, both mask registers read 32'hFFFF_FFFF and irq is low.
- R2: A high strobe on rx_evt[i] or tx_evt[i] adds one to that counter on the same clock edge. Strobes on several lines in one cycle are each counted.
- R3: The receive alignment counter (rx_evt[1]) is 12 bits wide. The other six receive counters are 16 bits wide, and all seven transmit counters are 12 bits wide. Reads are zero-extended, and a write keeps only the low counter-width bits.
- R4: An increment from the all-ones value leaves the counter at 0 and sets its carry bit on the same edge.
- R5: The receive carry bit positions, in strobe index order 0..6, are 14, 8, 7, 6, 3, 2, 0. These map to frame check, alignment, length, code, overrun, fragment and drop.
- R6: The transmit carry bit positions, in strobe index order 0..6, are 6, 8, 5, 4, 2, 15, 16. These map to single collision, deferred, multiple collision, late collision, total collisions, underrun and oversize.
- R7: A write to a carry register clears each bit where the data holds a 1 and leaves every other bit as it was. Bits that belong to no counter always read 0.
- R8: When a wrap and a clearing write hit the same carry bit in one cycle, the bit stays set.
- R9: A write to a counter loads the written value, so writing zero clears it. A write beats a strobe on the same counter in the same cycle.
- R10: Mask registers read back what was written. irq is high exactly while some carry bit in either register has a zero mask bit, and it drops once those bits are cleared or masked.
- R11: The address map is as follows. Receive counters sit at 0..6 and transmit counters at 8..14, both in strobe index order. The receive carry register is at 16, the receive mask at 17, the transmit carry at 18 and the transmit mask at 19. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 7 | Receive event strobes, one per counter |
| tx_evt | input | 7 | Transmit event strobes, one per counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Register address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Read data for reg_addr, combinational |
| irq | output | 1 | Unmasked carry pending |

## Verification
The bench preloads every counter to all ones and fires its strobe. A design with a swapped or wrong carry position then lights the wrong bit, and a design with a wrong width wraps at the wrong count or reads back extra bits. It forces a clearing write and a wrap onto the same carry bit in one cycle. A design that gives the clear priority loses a revolution of the count there. It also writes zero to carry registers and clears single bits while other bits are pending, which catches designs that write instead of clearing or that clear the whole register. It steps the masks one bit at a time on both carry registers, which exposes an irq that ignores the masks or misses the transmit side.

// File: rtl/mac_err_stats.sv
module mac_err_stats #(
  parameter int RX_W  = 16,
  parameter int ALN_W = 12,
  parameter int TX_W  = 12,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    rx_evt,
  input  logic [6:0]    tx_evt,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int NEV = 7;
  localparam int RX_POS [NEV] = '{14, 8, 7, 6, 3, 2, 0};
  localparam int TX_POS [NEV] = '{6, 8, 5, 4, 2, 15, 16};
  localparam int TX_BASE = 8;
  localparam int A_RXC = 16;
  localparam int A_RXM = 17;
  localparam int A_TXC = 18;
  localparam int A_TXM = 19;

  logic [DW-1:0] rx_cnt [NEV];
  logic [DW-1:0] tx_cnt [NEV];
  logic [NEV-1:0] rx_wrap, tx_wrap;
  logic [DW-1:0] rx_set, tx_set;
  logic [DW-1:0] rx_carry, tx_carry, rx_mask, tx_mask;
  logic [DW-1:0] rx_clr, tx_clr;

  for (genvar i = 0; i < NEV; i++) begin : g_rx
    localparam int W = (i == 1) ? ALN_W : RX_W;
    logic [W-1:0] c;
    logic hit;
    assign hit = reg_we && (reg_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         c <= '0;
      else if (hit)       c <= reg_wdata[W-1:0];
      else if (rx_evt[i]) c <= c + 1'b1;
    assign rx_wrap[i] = !hit && rx_evt[i] && (&c);
    assign rx_cnt[i]  = DW'(c);
  end

  for (genvar i = 0; i < NEV; i++) begin : g_tx
    logic [TX_W-1:0] c;
    logic hit;
    assign hit = reg_we && (reg_addr == AW'(TX_BASE + i));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         c <= '0;
      else if (hit)       c <= reg_wdata[TX_W-1:0];
      else if (tx_evt[i]) c <= c + 1'b1;
    assign tx_wrap[i] = !hit && tx_evt[i] && (&c);
    assign tx_cnt[i]  = DW'(c);
  end

  always_comb begin
    rx_set = '0;
    tx_set = '0;
    for (int i = 0; i < NEV; i++) begin
      if (rx_wrap[i]) rx_set[RX_POS[i]] = 1'b1;
      if (tx_wrap[i]) tx_set[TX_POS[i]] = 1'b1;
    end
  end

  assign rx_clr = (reg_we && reg_addr == AW'(A_RXC)) ? reg_wdata : '0;
  assign tx_clr = (reg_we && reg_addr == AW'(A_TXC)) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_carry <= '0;
      tx_carry <= '0;
      rx_mask  <= '1;
      tx_mask  <= '1;
    end else begin
      rx_carry <= (rx_carry & ~rx_clr) | rx_set;
      tx_carry <= (tx_carry & ~tx_clr) | tx_set;
      if (reg_we && reg_addr == AW'(A_RXM)) rx_mask <= reg_wdata;
      if (reg_we && reg_addr == AW'(A_TXM)) tx_mask <= reg_wdata;
    end

  assign irq = |(rx_carry & ~rx_mask) || |(tx_carry & ~tx_mask);

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NEV; i++) begin
      if (reg_addr == AW'(i))           reg_rdata = rx_cnt[i];
      if (reg_addr == AW'(TX_BASE + i)) reg_rdata = tx_cnt[i];
    end
    if (reg_addr == AW'(A_RXC)) reg_rdata = rx_carry;
    if (reg_addr == AW'(A_RXM)) reg_rdata = rx_mask;
    if (reg_addr == AW'(A_TXC)) reg_rdata = tx_carry;
    if (reg_addr == AW'(A_TXM)) reg_rdata = tx_mask;
  end
endmodule

// File: rtl/mac_err_stats_chk.sv
module mac_err_stats_chk #(
  parameter int RX_W = 16,
  parameter int TX_W = 12,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    rx_evt,
  input logic [6:0]    tx_evt,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          irq,
  input logic [DW-1:0] rx_c0,
  input logic [DW-1:0] tx_c0,
  input logic [DW-1:0] rx_carry,
  input logic [DW-1:0] tx_carry,
  input logic [DW-1:0] rx_mask
);
  localparam logic [DW-1:0] RX_MAX = DW'((64'd1 << RX_W) - 1);
  localparam logic [DW-1:0] TX_MAX = DW'((64'd1 << TX_W) - 1);
  logic wr_rx0, wr_tx0, clr_rx14;
  assign wr_rx0   = reg_we && reg_addr == AW'(0);
  assign wr_tx0   = reg_we && reg_addr == AW'(8);
  assign clr_rx14 = reg_we && reg_addr == AW'(16) && reg_wdata[14];

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt[0] && !wr_rx0 && rx_c0 != RX_MAX) |=> rx_c0 == $past(rx_c0) + 1);

  assert_wrap_sets_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt[0] && !wr_rx0 && rx_c0 == RX_MAX) |=> (rx_c0 == '0 && rx_carry[14]));

  assert_tx_carry_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt[0] && !wr_tx0 && tx_c0 == TX_MAX) |=> (tx_c0 == '0 && tx_carry[6]));

  assert_carry_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_carry[14] && !clr_rx14) |=> rx_carry[14]);

  assert_wrap_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx14 && rx_evt[0] && !wr_rx0 && rx_c0 == RX_MAX) |=> rx_carry[14]);

  assert_counter_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rx0 |=> rx_c0 == DW'($past(reg_wdata[RX_W-1:0])));

  assert_irq_on_unmasked_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt[0] && !wr_rx0 && rx_c0 == RX_MAX && !rx_mask[14] &&
     !(reg_we && reg_addr == AW'(17))) |=> irq);
endmodule

bind mac_err_stats mac_err_stats_chk #(.RX_W(RX_W), .TX_W(TX_W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .rx_c0(rx_cnt[0]), .tx_c0(tx_cnt[0]), .rx_carry(rx_carry),
  .tx_carry(tx_carry), .rx_mask(rx_mask)
);

// File: tb/mac_err_stats_tb.sv
`timescale 1ns/1ps
module mac_err_stats_tb;
  logic clk = 0, rst_n = 0;
  logic [6:0] rx_evt = '0, tx_evt = '0;
  logic reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  int RXP [7] = '{14, 8, 7, 6, 3, 2, 0};
  int TXP [7] = '{6, 8, 5, 4, 2, 15, 16};

  always #2.5 clk = ~clk;

  mac_err_stats u_dut (.clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  function automatic int rxw(int i); return (i == 1) ? 12 : 16; endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ev(int a, logic [31:0] d, logic [6:0] rx, logic [6:0] tx, bit we);
    @(negedge clk);
    reg_we = we; reg_addr = 5'(a); reg_wdata = d; rx_evt = rx; tx_evt = tx;
    @(negedge clk);
    reg_we = 0; rx_evt = '0; tx_evt = '0;
  endtask
  task automatic wr(int a, logic [31:0] d); wr_ev(a, d, '0, '0, 1); endtask
  task automatic ev(logic [6:0] rx, logic [6:0] tx); wr_ev(0, 0, rx, tx, 0); endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic irq_chk(bit exp, string req);
    #1 check(irq === exp, req, 32'(irq), 32'(exp));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 7; i++) begin
      rd_chk(i, 0, "R1 rx counter");
      rd_chk(8 + i, 0, "R1 tx counter");
    end
    rd_chk(16, 0, "R1 rx carry");
    rd_chk(18, 0, "R1 tx carry");
    rd_chk(17, 32'hFFFF_FFFF, "R1 rx mask");
    rd_chk(19, 32'hFFFF_FFFF, "R1 tx mask");
    irq_chk(0, "R1 irq");
    rd_chk(7, 0, "R11 hole 7");
    rd_chk(15, 0, "R11 hole 15");
    rd_chk(20, 0, "R11 hole 20");
    rd_chk(31, 0, "R11 hole 31");
  endtask

  task automatic t_count;
    ev(7'h7F, 7'h7F);
    ev(7'h7F, 7'h7F);
    ev(7'h05, 7'h40);
    for (int i = 0; i < 7; i++) begin
      rd_chk(i, 32'(2 + ((i == 0 || i == 2) ? 1 : 0)), "R2 rx count");
      rd_chk(8 + i, 32'(2 + ((i == 6) ? 1 : 0)), "R2 tx count");
    end
    for (int i = 0; i < 7; i++) begin
      wr(i, 0);
      wr(8 + i, 0);
    end
    for (int i = 0; i < 7; i++) begin
      rd_chk(i, 0, "R9 rx zero write");
      rd_chk(8 + i, 0, "R9 tx zero write");
    end
  endtask

  task automatic t_wrap_rx;
    for (int i = 0; i < 7; i++) begin
      wr(i, 32'hFFFF_FFFF);
      rd_chk(i, 32'((64'd1 << rxw(i)) - 1), "R3 rx width");
      ev(7'(1 << i), 0);
      rd_chk(i, 0, "R4 rx wrap to zero");
      rd_chk(16, 32'(1) << RXP[i], "R5 rx carry position");
      wr(16, 32'(1) << RXP[i]);
      rd_chk(16, 0, "R7 rx carry cleared");
    end
  endtask

  task automatic t_wrap_tx;
    for (int i = 0; i < 7; i++) begin
      wr(8 + i, 32'hFFFF_FFFF);
      rd_chk(8 + i, 32'hFFF, "R3 tx width");
      ev(0, 7'(1 << i));
      rd_chk(8 + i, 0, "R4 tx wrap to zero");
      rd_chk(18, 32'(1) << TXP[i], "R6 tx carry position");
      wr(18, 32'(1) << TXP[i]);
      rd_chk(18, 0, "R7 tx carry cleared");
    end
  endtask

  task automatic t_partial_clear;
    wr(0, 32'hFFFF);
    wr(6, 32'hFFFF);
    ev(7'h41, 0);
    rd_chk(16, 32'h4001, "R5 two rx carries");
    wr(16, 0);
    rd_chk(16, 32'h4001, "R7 zero write keeps carries");
    wr(16, 32'h4000);
    rd_chk(16, 32'h0001, "R7 single bit clear");
    wr(16, 32'hFFFF_FFFF);
    rd_chk(16, 0, "R7 all ones clear");
    wr(16, 32'hFFFF_FFFF);
    rd_chk(16, 0, "R7 undefined bits stay zero");
  endtask

  task automatic t_race;
    wr(0, 32'hFFFF);
    ev(7'h01, 0);
    rd_chk(16, 32'h4000, "R8 setup carry");
    wr(0, 32'hFFFF);
    wr_ev(16, 32'h4000, 7'h01, 0, 1);
    rd_chk(16, 32'h4000, "R8 wrap beats clear");
    rd_chk(0, 0, "R8 counter wrapped");
    wr(16, 32'h4000);
    rd_chk(16, 0, "R8 later clear works");
    wr(12, 32'hFFF);
    wr_ev(18, 32'h4, 0, 7'h10, 1);
    rd_chk(18, 32'h4, "R8 tx wrap beats clear");
    wr(18, 32'h4);
  endtask

  task automatic t_cnt_write;
    wr(2, 32'h1234);
    rd_chk(2, 32'h1234, "R9 load value");
    wr_ev(3, 32'h10, 7'h08, 0, 1);
    rd_chk(3, 32'h10, "R9 write beats event");
    wr(1, 32'hABCD);
    rd_chk(1, 32'hBCD, "R3 alignment truncates to 12 bits");
    wr(9, 32'h12345);
    rd_chk(9, 32'h345, "R3 tx truncates to 12 bits");
  endtask

  task automatic t_irq;
    wr(4, 32'hFFFF);
    ev(7'h10, 0);
    rd_chk(16, 32'h8, "R5 overrun carry");
    irq_chk(0, "R10 masked carry");
    wr(17, ~32'h4);
    irq_chk(0, "R10 other bit unmasked");
    rd_chk(17, ~32'h4, "R10 mask readback");
    wr(17, ~32'h8);
    irq_chk(1, "R10 unmasked carry");
    wr(16, 32'h8);
    irq_chk(0, "R10 cleared carry");
    wr(13, 32'hFFF);
    ev(0, 7'h20);
    irq_chk(0, "R10 tx masked");
    wr(19, ~(32'h1 << 15));
    irq_chk(1, "R10 tx unmasked");
    rd_chk(19, ~(32'h1 << 15), "R10 tx mask readback");
    wr(19, 32'hFFFF_FFFF);
    irq_chk(0, "R10 tx remasked");
    wr(18, 32'hFFFF_FFFF);
    wr(17, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_wrap_rx();
    t_wrap_tx();
    t_partial_clear();
    t_race();
    t_cnt_write();
    t_irq();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule